// File: doc/BRIEF.md
# Chained Dual-Channel Free-Running Time Base

This block builds a wide free-running time base out of two narrow up-counter channels. The low channel advances on a prescaled system clock. As it counts it drives a square wave that goes high when the count wraps to zero and low when it reaches half scale. The high channel is not fed by a carry. It advances on the rising edge of that square wave, and that edge is detected synchronously. The high channel therefore moves once per low-channel wrap, one cycle after the low half has already returned to zero.

Software-style commands drive the block. A block-wide sync pulse zeroes both channels and the prescaler at the same time. Each channel has write-one enable and disable command bits, and a status bit shows whether the channel is counting. Both halves are visible on their own read ports. Because the two halves are not updated in the same cycle, a small read sequencer gives a coherent wide value. It samples the upper half, then the lower half, then the upper half again, and it repeats until the two upper samples agree. The sequencer states are `RD_IDLE`, `RD_UPPER`, `RD_LOWER`, `RD_RECHECK` and `RD_DONE`. The transitions are:
- request accept: `RD_IDLE`→`RD_UPPER`
- upper taken: `RD_UPPER`→`RD_LOWER`
- lower taken: `RD_LOWER`→`RD_RECHECK`
- match: `RD_RECHECK`→`RD_DONE`
- mismatch retry: `RD_RECHECK`→`RD_LOWER`, keeping the fresh upper sample
- release: `RD_DONE`→`RD_IDLE`

A parameter selects a native variant instead. In that variant a single double-width channel counts and the second channel stays idle.

Top module: `chained_timebase32`

## Requirements
- R1: After reset both counts are zero, both status bits are 0, the wave output is low, and `rd_busy` and `rd_valid` are low.
- R2: `en_cmd[i]`=1 sets status bit `clk_sta[i]`, and `dis_cmd[i]`=1 clears it. Disable wins when both are set. A channel's count changes only while its status bit is 1, apart from sync. Bit 0 is the low channel and bit 1 is the high channel.
- R3: A `sync_cmd` pulse zeroes both counts, the prescaler and the wave output at the next edge. Enabled channels then count on from zero.
- R4: The low channel advances once every 4^`presc_sel` clock cycles, which is 1, 4, 16 or 64 for `presc_sel` 0..3. Its first advance after sync comes at the 4^`presc_sel`-th edge.
- R5: Each channel counts up from its all-ones value to zero with no compare reset.
- R6: The wave output goes high at the edge where the low count advances to 0. It goes low at the edge where the low count advances to 2^(CNT_W-1).
- R7: The high channel advances by exactly one at the edge after each wave rising edge, which is one cycle after the low wrap, and only while its status bit is 1.
- R8: A single-cycle `rd_req` taken while idle runs the upper/lower/upper sequence one edge per step, retrying from the lower step on mismatch. The sequence ends with `rd_valid` high for exactly one cycle while `rd_value` = {upper, lower}.
- R9: With `NATIVE_WIDE`=1 a single 2·CNT_W counter runs under channel-0 commands. `lo_count` and `hi_count` are its halves with no lag, `clk_sta[1]` stays 0, and the wave output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_sel | input | SEL_W | Prescaler select, divide by 4^sel |
| sync_cmd | input | 1 | Block-wide reset/restart pulse |
| en_cmd | input | 2 | Write-one channel enable commands |
| dis_cmd | input | 2 | Write-one channel disable commands |
| rd_req | input | 1 | Start a coherent wide read |
| lo_count | output | CNT_W | Low channel count |
| hi_count | output | CNT_W | High channel count |
| lo_wave | output | 1 | Low channel square-wave output |
| clk_sta | output | 2 | Per-channel counting status |
| rd_busy | output | 1 | Read sequencer active |
| rd_valid | output | 1 | Coherent value ready, one cycle |
| rd_value | output | 2*CNT_W | Coherent {upper, lower} value |

## Verification
Each prescaler setting is run for edge counts that land below a wrap, exactly on the wrap edge, one edge past it, and past several wraps. The on-wrap point tells the one-cycle high-half lag apart from an ideal carry. The points past a wrap separate correct wave clearing from a stuck wave. A native-width instance runs the same patterns and must show no lag. Two reads are tried. One sits mid-count and must finish without retry. The other straddles a wrap so that the upper samples disagree, and this separates a real retry from a naive split read. Disable ordering, disable-wins and a disabled high channel are each tried alone.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    // Coherent-read sequencer states
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_UPPER,
        RD_LOWER,
        RD_RECHECK,
        RD_DONE
    } rd_state_e;

    // Number of prescaler bits needed for the largest divisor 4^(2^sel_w - 1)
    function automatic int presc_bits(input int sel_w);
        int b;
        b = 2 * ((1 << sel_w) - 1);
        return (b < 1) ? 1 : b;
    endfunction

endpackage

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_cmd,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PC_W = ctb_pkg::presc_bits(SEL_W);

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] limit;

    // limit = 4^sel - 1; the shift may wrap in PC_W bits for the top setting
    always_comb begin
        limit = PC_W'((PC_W+1)'(1) << {sel, 1'b0}) - PC_W'(1);
        tick  = (pcnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (sync_cmd || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PC_W'(1);
        end
    end
endmodule

// File: rtl/ctb_channel.sv
module ctb_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_cmd,
    input  logic         en_cmd,
    input  logic         dis_cmd,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         running
);
    // Write-one status: disable has priority over enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (dis_cmd) begin
            running <= 1'b0;
        end else if (en_cmd) begin
            running <= 1'b1;
        end
    end

    // Free-running up-counter, natural wrap from all-ones to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (sync_cmd) begin
            count <= '0;
        end else if (running && step) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/ctb_wave.sv
module ctb_wave #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_cmd,
    input  logic         adv,
    input  logic [W-1:0] count,
    output logic         wave,
    output logic         rise
);
    localparam logic [W-1:0] SET_AT = '0;
    localparam logic [W-1:0] CLR_AT = W'(1) << (W - 1);

    logic [W-1:0] next_cnt;
    logic         wave_d;

    assign next_cnt = count + W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave   <= 1'b0;
            wave_d <= 1'b0;
        end else if (sync_cmd) begin
            wave   <= 1'b0;
            wave_d <= 1'b0;
        end else begin
            wave_d <= wave;
            if (adv && next_cnt == SET_AT) begin
                wave <= 1'b1;
            end else if (adv && next_cnt == CLR_AT) begin
                wave <= 1'b0;
            end
        end
    end

    // Synchronous rising-edge detect feeding the high channel
    assign rise = wave & ~wave_d;
endmodule

// File: rtl/ctb_read_fsm.sv
module ctb_read_fsm #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    output logic           busy,
    output logic           valid,
    output logic [2*W-1:0] value
);
    import ctb_pkg::*;

    rd_state_e    state_q, state_d;
    logic [W-1:0] up_q;
    logic [W-1:0] lo_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:    if (req) state_d = RD_UPPER;
            RD_UPPER:   state_d = RD_LOWER;
            RD_LOWER:   state_d = RD_RECHECK;
            RD_RECHECK: state_d = (hi == up_q) ? RD_DONE : RD_LOWER;
            RD_DONE:    state_d = RD_IDLE;
            default:    state_d = RD_IDLE;
        endcase
    end

    // Sample registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
            lo_q <= '0;
        end else begin
            unique case (state_q)
                RD_UPPER:   up_q <= hi;
                RD_LOWER:   lo_q <= lo;
                RD_RECHECK: if (hi != up_q) up_q <= hi;
                default:    ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy  = (state_q != RD_IDLE);
        valid = (state_q == RD_DONE);
        value = {up_q, lo_q};
    end
endmodule

// File: rtl/chained_timebase32.sv
module chained_timebase32 #(
    parameter int CNT_W       = 16,
    parameter int SEL_W       = 2,
    parameter bit NATIVE_WIDE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   presc_sel,
    input  logic               sync_cmd,
    input  logic [1:0]         en_cmd,
    input  logic [1:0]         dis_cmd,
    input  logic               rd_req,
    output logic [CNT_W-1:0]   lo_count,
    output logic [CNT_W-1:0]   hi_count,
    output logic               lo_wave,
    output logic [1:0]         clk_sta,
    output logic               rd_busy,
    output logic               rd_valid,
    output logic [2*CNT_W-1:0] rd_value
);
    localparam int WIDE_W = 2 * CNT_W;

    logic tick;

    ctb_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_cmd (sync_cmd),
        .sel      (presc_sel),
        .tick     (tick)
    );

    generate
        if (NATIVE_WIDE) begin : g_native
            logic [WIDE_W-1:0] wide_cnt;
            logic              wide_run;

            ctb_channel #(.W(WIDE_W)) u_wide (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_cmd (sync_cmd),
                .en_cmd   (en_cmd[0]),
                .dis_cmd  (dis_cmd[0]),
                .step     (tick),
                .count    (wide_cnt),
                .running  (wide_run)
            );

            assign lo_count = wide_cnt[CNT_W-1:0];
            assign hi_count = wide_cnt[WIDE_W-1:CNT_W];
            assign lo_wave  = 1'b0;
            assign clk_sta  = {1'b0, wide_run};
        end else begin : g_chain
            logic lo_run, hi_run, wave_rise;

            ctb_channel #(.W(CNT_W)) u_lo (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_cmd (sync_cmd),
                .en_cmd   (en_cmd[0]),
                .dis_cmd  (dis_cmd[0]),
                .step     (tick),
                .count    (lo_count),
                .running  (lo_run)
            );

            ctb_wave #(.W(CNT_W)) u_wave (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_cmd (sync_cmd),
                .adv      (tick & lo_run),
                .count    (lo_count),
                .wave     (lo_wave),
                .rise     (wave_rise)
            );

            ctb_channel #(.W(CNT_W)) u_hi (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_cmd (sync_cmd),
                .en_cmd   (en_cmd[1]),
                .dis_cmd  (dis_cmd[1]),
                .step     (wave_rise),
                .count    (hi_count),
                .running  (hi_run)
            );

            assign clk_sta = {hi_run, lo_run};
        end
    endgenerate

    ctb_read_fsm #(.W(CNT_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rd_req),
        .hi    (hi_count),
        .lo    (lo_count),
        .busy  (rd_busy),
        .valid (rd_valid),
        .value (rd_value)
    );
endmodule

// File: rtl/ctb_chk.sv
module ctb_chk #(
    parameter int CNT_W       = 16,
    parameter bit NATIVE_WIDE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_cmd,
    input logic [1:0]       en_cmd,
    input logic [1:0]       dis_cmd,
    input logic             rd_req,
    input logic [CNT_W-1:0] lo_count,
    input logic [CNT_W-1:0] hi_count,
    input logic             lo_wave,
    input logic [1:0]       clk_sta,
    input logic             rd_busy,
    input logic             rd_valid
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

    assert_dis_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd[0] |=> !clk_sta[0]);

    assert_en_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd[0] && !dis_cmd[0]) |=> clk_sta[0]);

    assert_lo_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_cmd && !clk_sta[0]) |=> $stable(lo_count));

    assert_sync_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_cmd |=> (lo_count == '0 && hi_count == '0 && !lo_wave));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_req_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_busy) |=> rd_busy);

    generate
        if (!NATIVE_WIDE) begin : g_chain_props
            assert_wave_rise_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(lo_wave) |-> (lo_count == '0));

            assert_wave_low_at_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (lo_count == HALF) |-> !lo_wave);

            assert_hi_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!sync_cmd && !clk_sta[1]) |=> $stable(hi_count));

            assert_hi_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !sync_cmd |=> (hi_count == $past(hi_count)
                               || hi_count == CNT_W'($past(hi_count) + 1'b1)));
        end else begin : g_native_props
            assert_native_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!clk_sta[1] && !lo_wave));
        end
    endgenerate
endmodule

bind chained_timebase32 ctb_chk #(
    .CNT_W       (CNT_W),
    .NATIVE_WIDE (NATIVE_WIDE)
) u_ctb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_cmd (sync_cmd),
    .en_cmd   (en_cmd),
    .dis_cmd  (dis_cmd),
    .rd_req   (rd_req),
    .lo_count (lo_count),
    .hi_count (hi_count),
    .lo_wave  (lo_wave),
    .clk_sta  (clk_sta),
    .rd_busy  (rd_busy),
    .rd_valid (rd_valid)
);

// File: tb/test_chained_timebase32.sv
module test_chained_timebase32;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   presc_sel = '0;
    logic         sync_cmd = 1'b0;
    logic [1:0]   en_cmd = '0;
    logic [1:0]   dis_cmd = '0;
    logic         rd_req = 1'b0;

    logic [W-1:0]   lo_c, hi_c, nlo_c, nhi_c;
    logic           wave, nwave;
    logic [1:0]     sta, nsta;
    logic           busy, valid, nbusy, nvalid;
    logic [2*W-1:0] rval, nrval;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz, 4-unit period

    chained_timebase32 #(.CNT_W(W), .SEL_W(2), .NATIVE_WIDE(1'b0)) i_chained_timebase32 (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .sync_cmd(sync_cmd),
        .en_cmd(en_cmd), .dis_cmd(dis_cmd), .rd_req(rd_req),
        .lo_count(lo_c), .hi_count(hi_c), .lo_wave(wave), .clk_sta(sta),
        .rd_busy(busy), .rd_valid(valid), .rd_value(rval));

    chained_timebase32 #(.CNT_W(W), .SEL_W(2), .NATIVE_WIDE(1'b1)) i_chained_timebase32_native (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .sync_cmd(sync_cmd),
        .en_cmd(en_cmd), .dis_cmd(dis_cmd), .rd_req(rd_req),
        .lo_count(nlo_c), .hi_count(nhi_c), .lo_wave(nwave), .clk_sta(nsta),
        .rd_busy(nbusy), .rd_valid(nvalid), .rd_value(nrval));

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] k;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        wv;
    } vec_t;

    // sel, edges after sync, expected low, high, wave (chained instance)
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'd10,    8'd10,  8'd0, 1'b0},
        '{2'd0, 32'd255,   8'd255, 8'd0, 1'b0},
        '{2'd0, 32'd256,   8'd0,   8'd0, 1'b1},
        '{2'd0, 32'd257,   8'd1,   8'd1, 1'b1},
        '{2'd0, 32'd700,   8'd188, 8'd2, 1'b0},
        '{2'd1, 32'd1000,  8'd250, 8'd0, 1'b0},
        '{2'd1, 32'd1025,  8'd0,   8'd1, 1'b1},
        '{2'd2, 32'd5000,  8'd56,  8'd1, 1'b1},
        '{2'd3, 32'd16385, 8'd0,   8'd1, 1'b1},
        '{2'd0, 32'd1,     8'd1,   8'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_sync(input logic [1:0] sel);
        @(negedge clk);
        presc_sel = sel;
        sync_cmd  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sync_cmd  = 1'b0;
    endtask

    task automatic run_edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [1:0] en, input logic [1:0] dis);
        @(negedge clk);
        en_cmd  = en;
        dis_cmd = dis;
        @(negedge clk);
        en_cmd  = '0;
        dis_cmd = '0;
    endtask

    task automatic do_read(input int pre, output logic [15:0] val, output int nvld);
        do_sync(2'd0);
        run_edges(pre);
        rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        nvld = 0;
        val  = '0;
        for (int i = 0; i < 20; i++) begin
            if (valid) begin
                if (nvld == 0) val = rval;
                nvld++;
            end
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] t;
        logic [15:0] rv;
        int          nv;

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 counts", {16'h0, hi_c, lo_c}, 32'h0);
        chk("R1 status", sta, 2'b00);
        chk("R1 wave/read", {wave, busy, valid}, 3'b000);

        // R2 no counting while disabled
        do_sync(2'd0);
        run_edges(5);
        chk("R2 disabled low holds", lo_c, 0);

        pulse(2'b11, 2'b00);
        chk("R2 enable status", sta, 2'b11);
        chk("R9 native high status idle", nsta, 2'b01);

        // Vector table: R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            do_sync(VEC[v].sel);
            run_edges(int'(VEC[v].k));
            chk($sformatf("R4/R5 vec%0d low", v), lo_c, VEC[v].lo);
            chk($sformatf("R7 vec%0d high", v), hi_c, VEC[v].hi);
            chk($sformatf("R6 vec%0d wave", v), wave, VEC[v].wv);
            t = VEC[v].k >> (2 * VEC[v].sel);
            chk($sformatf("R9 vec%0d native", v), {nhi_c, nlo_c, nwave}, {t[15:0], 1'b0});
        end
        chk("R3 sync cleared wave after vec8", wave, 1'b0);

        // R8 coherent reads
        do_read(99, rv, nv);
        chk("R8 mid-count read", rv, 16'h0065);
        chk("R8 valid one cycle", nv, 1);
        do_read(254, rv, nv);
        chk("R8 wrap-straddling read retries", rv, 16'h0102);
        chk("R8 valid one cycle after retry", nv, 1);

        // R2 disable holds count
        do_sync(2'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        dis_cmd = 2'b01;
        @(posedge clk);
        @(negedge clk);
        dis_cmd = 2'b00;
        run_edges(10);
        chk("R2 low held after disable", lo_c, 21);
        chk("R2 status after disable", sta, 2'b10);

        pulse(2'b10, 2'b10);
        chk("R2 disable wins", sta, 2'b00);

        // R7 high disabled: low wraps, high holds
        pulse(2'b01, 2'b00);
        do_sync(2'd0);
        run_edges(300);
        chk("R5 low after wrap", lo_c, 44);
        chk("R7 disabled high holds", hi_c, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule